// File: doc/BRIEF.md
# Chained Row Drive Sequencer

The block selects rows of a pixel matrix, one at a time, and drives two control lines for the row it currently holds. These lines are a gate line, which switches the row on for sampling, and a clear line, which empties the pixels of that row. The chip has 64 channels and one channel counter. For the channel the counter holds, a short program of up to eight steps is played through once per row. Each step sets the two lines and holds them for a programmed number of clocks. A typical program turns the gate on, adds a clear pulse, and then leaves the gate on so the pedestal can be sampled. The minimum row time is one clock, which leaves room for row rates of tens of MHz.

Many identical chips sit in a chain. The chip that is running passes a token to its neighbour once its last channel has finished. A direction flag decides whether the chip counts upward and hands off at the top, or counts downward and hands off at the bottom. The first chip of the chain is started by a local pulse. The step program and the direction flag can be written only while the chip is idle.

Top module: `row_steer_seq`

## Requirements
- R1: After reset the chip is idle: active_o is 0, every gate_o and clear_o bit is 0, and both chain outputs are 0.
- R2: An idle chip starts on a one-cycle pulse of start_i. It also starts on a pulse of chain_in_bottom_i when the direction flag is 0, or on a pulse of chain_in_top_i when the flag is 1. The chain input on the other side is ignored. The first active cycle, one clock after the pulse, is step 0 of channel 0 when the flag is 0, or of channel 63 when the flag is 1.
- R3: Each step holds its 2-bit level for dur+1 clocks: level bit 0 drives gate and level bit 1 drives clear of the active channel. After a step whose last marker is set, the next row starts again at step 0.
- R4: A program with no last marker plays steps 0 to 7 and then wraps to step 0.
- R5: At most one bit of gate_o and at most one bit of clear_o is 1, and only at the active channel. All other channels, and all channels while idle, are held at 0 (gate off, clear inactive).
- R6: With the flag at 0 the channel advances 0,1,...,63; with the flag at 1 it goes 63,62,...,0. chan_o shows the channel, and one row passes per channel.
- R7: When the final channel's row ends, active_o falls. In that same cycle a one-cycle pulse appears on chain_out_top_o (flag 0) or chain_out_bottom_o (flag 1); the other chain output stays 0.
- R8: Writes to the step memory (wr_en_i) and to the direction flag (dir_wr_i) are ignored while active_o is 1.
- R9: Start or chain inputs that arrive while the chip is active have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one step of the program |
| wr_addr_i | input | 3 | Step index to write |
| wr_level_i | input | 2 | Step level: bit 0 gate, bit 1 clear |
| wr_dur_i | input | 8 | Step duration minus one, in clocks |
| wr_last_i | input | 1 | Step is the last of the row |
| dir_wr_i | input | 1 | Write the direction flag |
| dir_i | input | 1 | Direction: 0 counts up, 1 counts down |
| start_i | input | 1 | Local start pulse |
| chain_in_top_i | input | 1 | Token from the neighbour above |
| chain_in_bottom_i | input | 1 | Token from the neighbour below |
| gate_o | output | 64 | Per-channel gate line |
| clear_o | output | 64 | Per-channel clear line |
| chain_out_top_o | output | 1 | Token to the neighbour above |
| chain_out_bottom_o | output | 1 | Token to the neighbour below |
| active_o | output | 1 | Chip holds the token |
| chan_o | output | 6 | Current channel |

## Verification
A wrong step index or duration count shows up at the gate and clear bits of the active channel within one row, so the bench compares every cycle of every row against a pattern expanded from the program it wrote. A channel counter that is off by one, or that runs the wrong way, moves the lit bit to a different position in the very next row. A fault in the end-of-chip logic appears as a token pulse on the wrong side, or one cycle early or late; the bench checks this against the exact cycle count of 64 rows. Ignored writes and ignored triggers are checked by replaying a full run afterwards and watching for any change in pattern or end cycle.

// File: rtl/row_steer_pkg.sv
package row_steer_pkg;
  localparam int unsigned DUR_W = 8;

  typedef struct packed {
    logic [1:0]       level;  // bit0 gate, bit1 clear
    logic [DUR_W-1:0] dur;    // hold time minus one
    logic             last;
  } step_t;
endpackage

// File: rtl/row_steer_prog.sv
module row_steer_prog
  import row_steer_pkg::*;
#(
  parameter int unsigned N_STEP = 8,
  localparam int unsigned ST_W = $clog2(N_STEP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lock_i,
  input  logic            wr_en_i,
  input  logic [ST_W-1:0] wr_addr_i,
  input  step_t           wr_step_i,
  input  logic            dir_wr_i,
  input  logic            dir_i,
  input  logic [ST_W-1:0] rd_addr_i,
  output step_t           rd_step_o,
  output logic            dir_o
);
  step_t mem_q [N_STEP];

  for (genvar s = 0; s < N_STEP; s++) begin : g_step
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[s] <= '{level: 2'b00, dur: '0, last: 1'b1};
      else if (wr_en_i && !lock_i && wr_addr_i == ST_W'(s)) mem_q[s] <= wr_step_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_o <= 1'b0;
    else if (dir_wr_i && !lock_i) dir_o <= dir_i;
  end

  assign rd_step_o = mem_q[rd_addr_i];
endmodule

// File: rtl/row_steer_step.sv
module row_steer_step
  import row_steer_pkg::*;
#(
  parameter int unsigned N_STEP = 8,
  localparam int unsigned ST_W = $clog2(N_STEP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  step_t           cur_i,
  output logic [ST_W-1:0] idx_o,
  output logic            row_done_o
);
  logic [DUR_W-1:0] cnt_q;
  logic             step_end;

  assign step_end   = run_i && (cnt_q == cur_i.dur);
  assign row_done_o = step_end && (cur_i.last || idx_o == ST_W'(N_STEP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o <= '0;
      cnt_q <= '0;
    end else if (!run_i || row_done_o) begin
      idx_o <= '0;
      cnt_q <= '0;
    end else if (step_end) begin
      idx_o <= idx_o + 1'b1;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/row_steer_chan.sv
module row_steer_chan #(
  parameter int unsigned N_CH = 64,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic            row_done_i,
  input  logic            dir_i,
  output logic            active_o,
  output logic [CH_W-1:0] chan_o,
  output logic            out_top_o,
  output logic            out_bot_o
);
  localparam logic [CH_W-1:0] CH_MAX = CH_W'(N_CH - 1);
  logic at_end;

  assign at_end = dir_i ? (chan_o == '0) : (chan_o == CH_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o  <= 1'b0;
      chan_o    <= '0;
      out_top_o <= 1'b0;
      out_bot_o <= 1'b0;
    end else begin
      out_top_o <= 1'b0;
      out_bot_o <= 1'b0;
      if (trig_i) begin
        active_o <= 1'b1;
        chan_o   <= dir_i ? CH_MAX : '0;
      end else if (row_done_i) begin
        if (at_end) begin
          active_o  <= 1'b0;
          out_top_o <= !dir_i;
          out_bot_o <= dir_i;
        end else begin
          chan_o <= dir_i ? chan_o - 1'b1 : chan_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/row_steer_seq.sv
module row_steer_seq
  import row_steer_pkg::*;
#(
  parameter int unsigned N_CH   = 64,
  parameter int unsigned N_STEP = 8,
  localparam int unsigned CH_W = $clog2(N_CH),
  localparam int unsigned ST_W = $clog2(N_STEP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ST_W-1:0]  wr_addr_i,
  input  logic [1:0]       wr_level_i,
  input  logic [DUR_W-1:0] wr_dur_i,
  input  logic             wr_last_i,
  input  logic             dir_wr_i,
  input  logic             dir_i,
  input  logic             start_i,
  input  logic             chain_in_top_i,
  input  logic             chain_in_bottom_i,
  output logic [N_CH-1:0]  gate_o,
  output logic [N_CH-1:0]  clear_o,
  output logic             chain_out_top_o,
  output logic             chain_out_bottom_o,
  output logic             active_o,
  output logic [CH_W-1:0]  chan_o
);
  step_t           cur_step;
  logic [ST_W-1:0] step_idx;
  logic            dir_q;
  logic            row_done;
  logic            trig;

  // token from below when counting up, from above when counting down
  assign trig = !active_o &&
                (start_i || (dir_q ? chain_in_top_i : chain_in_bottom_i));

  row_steer_prog #(.N_STEP(N_STEP)) u_prog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (active_o),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_step_i ('{level: wr_level_i, dur: wr_dur_i, last: wr_last_i}),
    .dir_wr_i  (dir_wr_i),
    .dir_i     (dir_i),
    .rd_addr_i (step_idx),
    .rd_step_o (cur_step),
    .dir_o     (dir_q)
  );

  row_steer_step #(.N_STEP(N_STEP)) u_step (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (active_o),
    .cur_i      (cur_step),
    .idx_o      (step_idx),
    .row_done_o (row_done)
  );

  row_steer_chan #(.N_CH(N_CH)) u_chan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .row_done_i (row_done),
    .dir_i      (dir_q),
    .active_o   (active_o),
    .chan_o     (chan_o),
    .out_top_o  (chain_out_top_o),
    .out_bot_o  (chain_out_bottom_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic sel;
    assign sel        = active_o && (chan_o == CH_W'(c));
    assign gate_o[c]  = sel && cur_step.level[0];
    assign clear_o[c] = sel && cur_step.level[1];
  end
endmodule

// File: rtl/row_steer_chk.sv
module row_steer_chk #(
  parameter int unsigned N_CH = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            active_i,
  input logic [N_CH-1:0] gate_i,
  input logic [N_CH-1:0] clear_i,
  input logic            out_top_i,
  input logic            out_bot_i,
  input logic            dir_i
);
  // R5
  onehot_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gate_i) && $onehot0(clear_i));

  // R5
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (gate_i == '0 && clear_i == '0));

  // R7
  handoff_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_top_i |-> ($fell(active_i) && !out_bot_i));

  // R7
  handoff_bot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_bot_i |-> ($fell(active_i) && !out_top_i));

  // R8
  dir_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i)) |-> $stable(dir_i));
endmodule

bind row_steer_seq row_steer_chk #(.N_CH(N_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .active_i  (active_o),
  .gate_i    (gate_o),
  .clear_i   (clear_o),
  .out_top_i (chain_out_top_o),
  .out_bot_i (chain_out_bottom_o),
  .dir_i     (dir_q)
);

// File: tb/row_steer_seq_bench.sv
module row_steer_seq_bench;
  localparam int N_CH = 64;
  localparam int N_STEP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_last = 0, dir_wr = 0, dir = 0;
  logic start = 0, cin_top = 0, cin_bot = 0;
  logic [2:0] wr_addr = '0;
  logic [1:0] wr_level = '0;
  logic [7:0] wr_dur = '0;
  logic [N_CH-1:0] gate, clear;
  logic cout_top, cout_bot, active;
  logic [5:0] chan;

  int total = 0, bad = 0;
  logic [1:0] m_lvl [N_STEP];
  int m_dur [N_STEP];
  logic m_last [N_STEP];
  logic [1:0] pat [N_STEP*256];
  int pat_len;

  always #2 clk = ~clk;

  row_steer_seq u_row_steer_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_level_i(wr_level), .wr_dur_i(wr_dur), .wr_last_i(wr_last),
    .dir_wr_i(dir_wr), .dir_i(dir), .start_i(start),
    .chain_in_top_i(cin_top), .chain_in_bottom_i(cin_bot),
    .gate_o(gate), .clear_o(clear), .chain_out_top_o(cout_top),
    .chain_out_bottom_o(cout_bot), .active_o(active), .chan_o(chan)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_step(int a, logic [1:0] l, int d, logic last);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_level = l; wr_dur = 8'(d); wr_last = last;
    @(negedge clk);
    wr_en = 0;
    if (!active) begin m_lvl[a] = l; m_dur[a] = d; m_last[a] = last; end
  endtask

  task automatic wr_dir(logic d);
    @(negedge clk);
    dir_wr = 1; dir = d;
    @(negedge clk);
    dir_wr = 0;
  endtask

  function automatic void build_pat();
    pat_len = 0;
    for (int s = 0; s < N_STEP; s++) begin
      for (int k = 0; k <= m_dur[s]; k++) begin
        pat[pat_len] = m_lvl[s];
        pat_len++;
      end
      if (m_last[s]) break;
    end
  endfunction

  // pulse trigger: 0 start, 1 top, 2 bottom; on negedge after return cycle 0 is visible
  task automatic pulse(int kind);
    @(negedge clk);
    start = (kind == 0); cin_top = (kind == 1); cin_bot = (kind == 2);
    @(negedge clk);
    start = 0; cin_top = 0; cin_bot = 0;
  endtask

  // full run check; disturb=1 injects writes and triggers mid-run (R8, R9)
  task automatic run_chk(string req, logic d, int kind, bit disturb);
    int bad0 = bad;
    build_pat();
    pulse(kind);
    for (int ch = 0; ch < N_CH; ch++) begin
      for (int p = 0; p < pat_len; p++) begin
        int c = d ? N_CH - 1 - ch : ch;
        logic [N_CH-1:0] eg = pat[p][0] ? (64'd1 << c) : '0;
        logic [N_CH-1:0] ec = pat[p][1] ? (64'd1 << c) : '0;
        if (active !== 1'b1 || chan !== 6'(c) || gate !== eg || clear !== ec) begin
          bad++;
          $display("FAIL %s ch=%0d p=%0d act=%b/%0d/%h/%h exp=1/%0d/%h/%h",
                   req, ch, p, active, chan, gate, clear, c, eg, ec);
        end
        if (disturb && ch == 10 && p == 0) begin
          start = 1; cin_top = 1; cin_bot = 1; wr_en = 1; wr_addr = 0;
          wr_level = ~m_lvl[0]; wr_dur = 8'(m_dur[0] + 1); wr_last = 1;
          dir_wr = 1; dir = ~d;
        end else begin
          start = 0; cin_top = 0; cin_bot = 0; wr_en = 0; dir_wr = 0;
        end
        @(negedge clk);
      end
    end
    total++;
    if (bad != bad0) $display("FAIL %s pattern mismatches=%0d exp=0", req, bad - bad0);
    check({req, " R7 end"}, {active, cout_top, cout_bot},
          {1'b0, !d, d});
    @(negedge clk);
    check({req, " R7 pulse width"}, {active, cout_top, cout_bot}, 3'b000);
  endtask

  task automatic t_reset();
    check("R1 idle", {active, cout_top, cout_bot}, 3'b000);
    check("R1 lines", {gate, clear}, '0);
  endtask

  task automatic t_up();
    wr_step(0, 2'b01, 1, 0);
    wr_step(1, 2'b11, 0, 0);
    wr_step(2, 2'b01, 2, 1);
    wr_dir(0);
    run_chk("R3 R6 up", 1'b0, 0, 0);
  endtask

  task automatic t_down();
    wr_dir(1);
    run_chk("R2 R6 down from top", 1'b1, 1, 0);
  endtask

  task automatic t_wrong_side();
    pulse(2);  // dir=1: bottom token ignored
    check("R2 wrong side dir1", {active, gate, clear}, '0);
    repeat (3) @(negedge clk);
    check("R2 wrong side stays idle", {active, chan}, '0 | 7'(chan));
    wr_dir(0);
    pulse(1);
    check("R2 wrong side dir0", {active, gate, clear}, '0);
    run_chk("R2 bottom token up", 1'b0, 2, 0);
  endtask

  task automatic t_locked();
    run_chk("R8 R9 disturbed", 1'b0, 0, 1);
    run_chk("R8 program kept", 1'b0, 0, 0);
  endtask

  task automatic t_short_and_wrap();
    wr_step(0, 2'b10, 0, 1);
    run_chk("R3 one cycle row", 1'b0, 0, 0);
    for (int s = 0; s < N_STEP; s++) wr_step(s, 2'(s), 0, 0);
    wr_dir(1);
    run_chk("R4 wrap no last", 1'b1, 0, 0);
  endtask

  initial begin
    bit done = 0;
    for (int s = 0; s < N_STEP; s++) begin m_lvl[s] = 0; m_dur[s] = 0; m_last[s] = 1; end
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_up();
        t_down();
        t_wrong_side();
        t_locked();
        t_short_and_wrap();
        done = 1;
      end
      begin
        repeat (150000) @(negedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog act=hung exp=done");
        end
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule